// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block derives two single-cycle clock-enable ticks from one reference clock. The serial tick runs at sixteen times the bit rate of an asynchronous serial port. The infrared tick targets about 1,843,200 Hz and drives an infrared pulse shaper. Each tick has a programmable whole-cycle divisor and a 4-bit fractional correction in sixteenths of a reference clock. The fraction lengthens some periods by one clock and spreads those longer periods evenly, so the average period can fall between two whole counts.

Software programs the block through a write-only 16-bit register port. The infrared side also has a small control register. It holds a level for the transmit pulse-width select and produces a one-cycle pulse that clears the pulse-width error.

Each channel is one small state machine with two states. DV_COUNT counts the base period. DV_EXTRA adds the single stretch clock. There are three transitions:
- DV_COUNT to DV_EXTRA at the end of a base count when a stretch is pending.
- DV_EXTRA to DV_COUNT after the stretch clock.
- Any state to DV_COUNT on a restart.

A period that needs no stretch ends in DV_COUNT and stays there. Each period end adds the fraction index into a 4-bit phase accumulator. The carry out of that addition schedules a stretch of the following period.

Register map (address on `reg_addr`, data on `reg_wdata`):
- Address 0: serial count C, in bits 11:0.
- Address 1: serial fraction index, in bits 7:4.
- Address 2: infrared count I, in bits 3:0.
- Address 3: infrared fraction index, in bits 7:4.
- Address 4: infrared control. Bit 1 is the pulse-width select. Bit 0 is write-one-to-clear for the pulse-width error.
- Addresses 5 to 7 are ignored.

The serial base period is (C+1)×16 clocks. The infrared base period is I+1 clocks.

Top module: `frac_tick_gen`

## Requirements
- R1: With serial count C and serial fraction index f, any 16 consecutive serial ticks span exactly 16×(C+1)×16 + f reference clocks.
- R2: With infrared count I and infrared fraction index f, any 16 consecutive infrared ticks span exactly 16×(I+1) + f reference clocks.
- R3: A fraction index is taken from bits 7:4 of a write to address 1 or 3. All other data bits of that write have no effect on the tick spacing.
- R4: The infrared count is taken from bits 3:0 of a write to address 2. A write whose bits 3:0 are 0 is rejected: the count, the tick spacing and the phase stay as they were.
- R5: An accepted write to a channel's count or fraction register restarts that channel's period counter and accumulator. The channel's first tick then appears exactly one base period after the write edge, with no tick before it.
- R6: Each tick is high for exactly one reference clock.
- R7: A write to address 4 sets the pulse-width select level to data bit 1. If data bit 0 is 1, the error-clear output is high for exactly the one cycle after the write. If data bit 0 is 0, no clear pulse appears.
- R8: After reset the serial count is 0, the infrared count is 1, both fractions are 0 and the pulse-width select is 0. This gives a 16-tick span of 256 clocks on the serial tick and 32 clocks on the infrared tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| ser_tick | output | 1 | Serial 16x oversampling enable |
| ir_tick | output | 1 | Infrared pulse-shaper enable |
| ir_pw_sel | output | 1 | Transmit pulse-width select level |
| ir_err_clr | output | 1 | One-cycle pulse-width error clear |

## Verification
The assertions take some things about the register port for granted:
- `reg_wr` is a clean single-cycle strobe.
- Address and data are valid whenever the strobe is high.
- Between writes, the port is idle long enough that a channel's own restart is the only thing that cuts a period short.

The stimulus keeps within these assumptions. It issues each write as one strobe cycle between falling edges. It waits for the scoreboard to drain its measurement window before the next write, so no register changes while a 16-tick span is being timed.

// File: rtl/frac_tick_pkg.sv
package frac_tick_pkg;

    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 3;
    localparam int FRAC_W   = 4;
    localparam int FRAC_LSB = 4;
    localparam int NUM_CH   = 2;
    localparam int CH_SER   = 0;
    localparam int CH_IR    = 1;

    typedef enum logic [ADDR_W-1:0] {
        RG_SER_CNT  = 3'd0,
        RG_SER_FRAC = 3'd1,
        RG_IR_CNT   = 3'd2,
        RG_IR_FRAC  = 3'd3,
        RG_IR_CTRL  = 3'd4
    } reg_sel_e;

    typedef enum logic {
        DV_COUNT = 1'b0,
        DV_EXTRA = 1'b1
    } div_state_e;

endpackage

// File: rtl/tick_regs.sv
module tick_regs
    import frac_tick_pkg::*;
#(
    parameter int SER_CNT_W = 12,
    parameter int IR_CNT_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [DATA_W-1:0]       reg_wdata,
    output logic [SER_CNT_W-1:0]    ser_cnt,
    output logic [FRAC_W-1:0]       ser_frac,
    output logic [IR_CNT_W-1:0]     ir_cnt,
    output logic [FRAC_W-1:0]       ir_frac,
    output logic                    pw_sel,
    output logic                    err_clr,
    output logic [NUM_CH-1:0]       restart
);

    localparam logic [IR_CNT_W-1:0] IR_CNT_RST = IR_CNT_W'(1);

    logic [IR_CNT_W-1:0] ir_cnt_field;
    logic                ir_cnt_ok;
    logic                unused_wdata;

    assign ir_cnt_field = reg_wdata[IR_CNT_W-1:0];
    assign ir_cnt_ok    = (ir_cnt_field != '0);
    assign unused_wdata = ^reg_wdata;

    always_comb begin
        restart = '0;
        if (reg_wr) begin
            case (reg_addr)
                RG_SER_CNT,
                RG_SER_FRAC: restart[CH_SER] = 1'b1;
                RG_IR_CNT:   restart[CH_IR]  = ir_cnt_ok;
                RG_IR_FRAC:  restart[CH_IR]  = 1'b1;
                default:     restart         = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ser_cnt  <= '0;
            ser_frac <= '0;
            ir_cnt   <= IR_CNT_RST;
            ir_frac  <= '0;
            pw_sel   <= 1'b0;
            err_clr  <= 1'b0;
        end else begin
            err_clr <= 1'b0;
            if (reg_wr) begin
                case (reg_addr)
                    RG_SER_CNT:  ser_cnt  <= reg_wdata[SER_CNT_W-1:0];
                    RG_SER_FRAC: ser_frac <= reg_wdata[FRAC_LSB +: FRAC_W];
                    RG_IR_CNT:   if (ir_cnt_ok) ir_cnt <= ir_cnt_field;
                    RG_IR_FRAC:  ir_frac  <= reg_wdata[FRAC_LSB +: FRAC_W];
                    RG_IR_CTRL: begin
                        pw_sel  <= reg_wdata[1];
                        err_clr <= reg_wdata[0];
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/tick_divider.sv
module tick_divider
    import frac_tick_pkg::*;
#(
    parameter int PER_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [PER_W-1:0]  period,
    input  logic [FRAC_W-1:0] frac,
    output logic              tick
);

    div_state_e          state_q, state_d;
    logic [PER_W-1:0]    cnt_q;
    logic [FRAC_W-1:0]   acc_q;
    logic                stretch_q;
    logic                last_cnt;
    logic                period_done;
    logic [FRAC_W:0]     acc_sum;

    assign last_cnt = (cnt_q == period - PER_W'(1));
    assign acc_sum  = {1'b0, acc_q} + {1'b0, frac};

    // next state
    always_comb begin
        state_d     = state_q;
        period_done = 1'b0;
        unique case (state_q)
            DV_COUNT: begin
                if (last_cnt) begin
                    if (stretch_q) state_d = DV_EXTRA;
                    else           period_done = 1'b1;
                end
            end
            DV_EXTRA: begin
                state_d     = DV_COUNT;
                period_done = 1'b1;
            end
        endcase
        if (restart) state_d = DV_COUNT;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DV_COUNT;
        else        state_q <= state_d;
    end

    // counter, accumulator and tick
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            acc_q     <= '0;
            stretch_q <= 1'b0;
            tick      <= 1'b0;
        end else if (restart) begin
            cnt_q     <= '0;
            acc_q     <= '0;
            stretch_q <= 1'b0;
            tick      <= 1'b0;
        end else begin
            tick <= period_done;
            if (period_done) begin
                cnt_q              <= '0;
                {stretch_q, acc_q} <= acc_sum;
            end else if (state_q == DV_COUNT && !last_cnt) begin
                cnt_q <= cnt_q + PER_W'(1);
            end else begin
                cnt_q <= '0;
            end
        end
    end

endmodule

// File: rtl/frac_tick_gen.sv
module frac_tick_gen
    import frac_tick_pkg::*;
#(
    parameter int SER_CNT_W = 12,
    parameter int IR_CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic              ser_tick,
    output logic              ir_tick,
    output logic              ir_pw_sel,
    output logic              ir_err_clr
);

    localparam int PER_W = SER_CNT_W + 5;

    logic [SER_CNT_W-1:0] ser_cnt_w;
    logic [IR_CNT_W-1:0]  ir_cnt_w;
    logic [FRAC_W-1:0]    frac_w  [NUM_CH];
    logic [PER_W-1:0]     base_w  [NUM_CH];
    logic [NUM_CH-1:0]    restart_w;
    logic [NUM_CH-1:0]    tick_w;

    tick_regs #(
        .SER_CNT_W (SER_CNT_W),
        .IR_CNT_W  (IR_CNT_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .ser_cnt   (ser_cnt_w),
        .ser_frac  (frac_w[CH_SER]),
        .ir_cnt    (ir_cnt_w),
        .ir_frac   (frac_w[CH_IR]),
        .pw_sel    (ir_pw_sel),
        .err_clr   (ir_err_clr),
        .restart   (restart_w)
    );

    assign base_w[CH_SER] = (PER_W'(ser_cnt_w) + PER_W'(1)) << 4;
    assign base_w[CH_IR]  = PER_W'(ir_cnt_w) + PER_W'(1);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        tick_divider #(.PER_W(PER_W)) u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (restart_w[g]),
            .period  (base_w[g]),
            .frac    (frac_w[g]),
            .tick    (tick_w[g])
        );
    end

    assign ser_tick = tick_w[CH_SER];
    assign ir_tick  = tick_w[CH_IR];

endmodule

// File: rtl/frac_tick_chk.sv
module frac_tick_chk
    import frac_tick_pkg::*;
#(
    parameter int IR_CNT_W = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [DATA_W-1:0]   reg_wdata,
    input logic                ser_tick,
    input logic                ir_tick,
    input logic                ir_pw_sel,
    input logic                ir_err_clr,
    input logic [IR_CNT_W-1:0] ir_cnt
);

    logic ser_wr, ir_wr_ok, ir_zero_wr, ctrl_wr;

    assign ser_wr     = reg_wr && (reg_addr == RG_SER_CNT || reg_addr == RG_SER_FRAC);
    assign ir_zero_wr = reg_wr && reg_addr == RG_IR_CNT && reg_wdata[IR_CNT_W-1:0] == '0;
    assign ir_wr_ok   = reg_wr && (reg_addr == RG_IR_FRAC ||
                        (reg_addr == RG_IR_CNT && reg_wdata[IR_CNT_W-1:0] != '0));
    assign ctrl_wr    = reg_wr && reg_addr == RG_IR_CTRL;

    AST_SER_TICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ser_tick |=> !ser_tick); // R6
    AST_IR_TICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ir_tick |=> !ir_tick); // R6
    AST_SER_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ser_wr |=> !ser_tick); // R5
    AST_IR_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ir_wr_ok |=> !ir_tick); // R5
    AST_IR_ZERO_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        ir_zero_wr |=> $stable(ir_cnt)); // R4
    AST_IR_CNT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        ir_cnt != '0); // R4
    AST_CTRL_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (ir_pw_sel == $past(reg_wdata[1]) && ir_err_clr == $past(reg_wdata[0]))); // R7
    AST_ERRCLR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        ir_err_clr |-> $past(ctrl_wr)); // R7

endmodule

bind frac_tick_gen frac_tick_chk #(.IR_CNT_W(IR_CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .ser_tick   (ser_tick),
    .ir_tick    (ir_tick),
    .ir_pw_sel  (ir_pw_sel),
    .ir_err_clr (ir_err_clr),
    .ir_cnt     (ir_cnt_w)
);

// File: tb/sim_frac_tick_gen.sv
module sim_frac_tick_gen;

    typedef struct {
        int    ch;
        int    exp;
        string tag;
    } win_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        ser_tick, ir_tick, ir_pw_sel, ir_err_clr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    win_t q[$];

    always #5 clk = ~clk;

    frac_tick_gen u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .ser_tick   (ser_tick),
        .ir_tick    (ir_tick),
        .ir_pw_sel  (ir_pw_sel),
        .ir_err_clr (ir_err_clr)
    );

    function automatic logic tick_of(int ch);
        return (ch == 0) ? ser_tick : ir_tick;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(int addr, int data);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = 3'(addr);
        reg_wdata = 16'(data);
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    // driver: push expected 16-tick span, wait for the monitor
    task automatic expect_span(int ch, int base, int frac, string tag);
        win_t it;
        it.ch  = ch;
        it.exp = 16 * base + frac;
        it.tag = tag;
        q.push_back(it);
        wait (q.size() == 0);
    endtask

    // monitor: time 16 ticks and compare with the head of the queue
    initial begin
        forever begin
            wait (q.size() > 0);
            begin
                win_t it;
                int   n;
                int   cyc;
                it = q[0];
                do @(negedge clk); while (!tick_of(it.ch));
                n = 0;
                cyc = 0;
                while (n < 16) begin
                    @(negedge clk);
                    cyc++;
                    if (tick_of(it.ch)) n++;
                end
                check(it.tag, cyc, it.exp);
                void'(q.pop_front());
            end
        end
    end

    task automatic first_tick(int ch, int exp_p, string tag);
        int k;
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!tick_of(ch) && k < 100000);
        check(tag, k, exp_p);
        @(negedge clk);
        check({tag, "/R6 width"}, int'(tick_of(ch)), 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        check("R8 pw_sel", int'(ir_pw_sel), 0);
        check("R8 err_clr", int'(ir_err_clr), 0);
        expect_span(0, 16, 0, "R8 serial");
        expect_span(1, 2, 0, "R8 ir");

        // R1 serial, every fraction index
        for (int f = 0; f < 16; f++) begin
            wr(1, f << 4);
            expect_span(0, 16, f, "R1 sweep");
        end
        wr(0, 5);
        wr(1, 9 << 4);
        expect_span(0, 96, 9, "R1 C5 f9");

        // R2 infrared, every fraction index
        wr(0, 0);
        wr(1, 0);
        wr(2, 2);
        for (int f = 0; f < 16; f++) begin
            wr(3, f << 4);
            expect_span(1, 3, f, "R2 sweep");
        end
        wr(2, 15);
        wr(3, 15 << 4);
        expect_span(1, 16, 15, "R2 I15 f15");

        // R3 field position
        wr(1, 16'hFF5F);
        expect_span(0, 16, 5, "R3 serial");
        wr(2, 2);
        wr(3, 16'h0A3C);
        expect_span(1, 3, 3, "R3 ir");

        // R4 count field and rejected zero
        wr(2, 3);
        wr(3, 0);
        expect_span(1, 4, 0, "R4 base");
        wr(2, 0);
        expect_span(1, 4, 0, "R4 zero rejected");
        wr(2, 16'hFFF0);
        expect_span(1, 4, 0, "R4 low-zero rejected");
        wr(2, 16'h0015);
        expect_span(1, 6, 0, "R4 upper ignored");

        // R5 restart timing
        wr(2, 4);
        wr(3, 0);
        first_tick(1, 5, "R5 ir first");
        wr(1, 0);
        first_tick(0, 16, "R5 serial first");

        // R7 control
        wr(4, 3);
        check("R7 pw_sel set", int'(ir_pw_sel), 1);
        check("R7 clr pulse", int'(ir_err_clr), 1);
        @(negedge clk);
        check("R7 clr one cycle", int'(ir_err_clr), 0);
        wr(4, 0);
        check("R7 pw_sel clear", int'(ir_pw_sel), 0);
        check("R7 no clr", int'(ir_err_clr), 0);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule